// File: doc/BRIEF.md
# Per-Area External Bus Cycle Controller

This block sequences the state strobes of external bus cycles for a processor whose external address space is cut into eight equal areas. The top three address bits pick the area. Each area has its own configuration: a data width of 8 or 16 bits, a two-state or three-state access length, and a 0 to 3 count of wait states that are inserted automatically. Areas can also be flagged by static inputs as DRAM, which always uses a four-state cycle, or as burst ROM, in which the beats after the first are short two-state beats. A request carries an address, a byte/word size and a read/write flag. It is accepted only while the controller is idle. The controller then drives exactly one of the strobes T1, T2, Tw, T3 or T4 in each clock cycle, together with a byte-lane select and the bus address, and it pulses done in the last state of the access.

A word access to an 8-bit area becomes two byte cycles. The even (upper) byte goes first and done appears only at the end of the second cycle. The global bus-mode output reports 16-bit operation whenever at least one area is configured 16 bits wide. The configuration is held in four 8-bit registers written through a small write port. Each request captures its area's settings when it is accepted.

Top module: `ext_bus_seq`

## Requirements
- R1: The area index is address bits [ADDR_W-1:ADDR_W-3]. After reset every area is 16-bit, three-state, with 3 wait states, so a byte read gives T1,T2,Tw,Tw,Tw,T3. After reset the strobes and done are low and ready is high.
- R2: bus16_mode is 1 when any width bit is 1, and 0 only when all eight width bits are 0.
- R3: An area whose state bit is 0 (and which is not DRAM) runs T1,T2 with no Tw, whatever its wait field holds.
- R4: A three-state area runs T1, T2, then n Tw, then T3, where n is its 2-bit wait field.
- R5: A DRAM area runs T1,T2,T3,T4 whatever its state bit. When its state bit is 1, n Tw states from its wait field are placed between T3 and T4. When the state bit is 0, no Tw is placed.
- R6: In a burst-ROM area a request with burst=1 runs T1,T2 with no Tw. A request with burst=0 follows R3/R4. The burst input has no effect in other areas. DRAM takes precedence over burst ROM.
- R7: byte_lane is {upper,lower}. A word to a 16-bit area gives 2'b11. A byte to a 16-bit area gives 2'b10 at an even address and 2'b01 at an odd one. Any access to an 8-bit area gives 2'b10.
- R8: A word to an 8-bit area runs two complete byte cycles with no idle state between them. The first is at the even address and the second at the even address plus one. There is one done, in the last state of the second cycle.
- R9: Exactly one strobe is high while a cycle runs. done is high for one clock, in the final state. ready is high only when no strobe is high, and a request is accepted only on an edge where ready is high.
- R10: Writes with cfg_sel 0 set the width bits (bit i = area i, 1 = 16-bit). cfg_sel 1 sets the state bits (1 = three-state). cfg_sel 2 sets the wait fields of areas 7..4 (bits [7:6] = area 7 down to [1:0] = area 4). cfg_sel 3 sets the wait fields of areas 3..0 (bits [7:6] = area 3 down to [1:0] = area 0). A request uses the settings held at its acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| dram_area | input | 8 | Static per-area DRAM flags |
| brom_area | input | 8 | Static per-area burst ROM flags |
| req_valid | input | 1 | Access request |
| req_addr | input | ADDR_W | Request address |
| req_wide | input | 1 | 1 = 16-bit access, 0 = byte |
| req_write | input | 1 | 1 = write |
| req_burst | input | 1 | Marks a burst beat after the first |
| ready | output | 1 | Controller idle, request can be taken |
| st_t1 | output | 1 | T1 state strobe |
| st_t2 | output | 1 | T2 state strobe |
| st_tw | output | 1 | Program wait state strobe |
| st_t3 | output | 1 | T3 state strobe |
| st_t4 | output | 1 | Fourth DRAM state strobe |
| bus_addr | output | ADDR_W | Address of the current byte or word cycle |
| bus_write | output | 1 | Direction of the current cycle |
| byte_lane | output | 2 | Active lanes {upper, lower} |
| bus16_mode | output | 1 | 16-bit bus mode |
| done | output | 1 | Access completion pulse |

## Verification
A configuration write and the acceptance of a request can land on the same clock edge. The case of interest is a write that changes the wait field of the very area being requested. The bench provokes it by raising cfg_we and req_valid in the same cycle. It checks that the accepted access keeps the Tw count set before the write, and that the next request to that area shows the new count. The last cycle of the first half of a split word and the start of its second half also meet on one edge. That case is judged by the absence of a done pulse and of an idle state between the halves, and by the odd address in the second T1.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    K_TWO   = 2'd0,
    K_THREE = 2'd1,
    K_DRAM  = 2'd2
  } kind_e;

  localparam logic [1:0] SEL_WIDTH = 2'd0;
  localparam logic [1:0] SEL_STATE = 2'd1;
  localparam logic [1:0] SEL_WHI   = 2'd2;
  localparam logic [1:0] SEL_WLO   = 2'd3;
endpackage

// File: rtl/ebs_cfg_regs.sv
module ebs_cfg_regs #(
  parameter int N_AREA = 8,
  parameter int WAIT_W = 2,
  parameter int REG_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [1:0]               sel,
  input  logic [REG_W-1:0]         wdata,
  output logic [N_AREA-1:0]        width_o,
  output logic [N_AREA-1:0]        three_o,
  output logic [N_AREA*WAIT_W-1:0] waits_o,
  output logic                     bus16_o
);
  import ebs_pkg::*;
  localparam int WV_W = N_AREA * WAIT_W;

  logic [N_AREA-1:0] width_q, three_q;
  logic [WV_W-1:0]   waits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= '1;
      three_q <= '1;
      waits_q <= '1;
    end else if (we) begin
      unique case (sel)
        SEL_WIDTH: width_q <= wdata[N_AREA-1:0];
        SEL_STATE: three_q <= wdata[N_AREA-1:0];
        SEL_WHI:   waits_q[WV_W-1:WV_W-REG_W] <= wdata;
        SEL_WLO:   waits_q[REG_W-1:0] <= wdata;
        default: ;
      endcase
    end
  end

  assign width_o = width_q;
  assign three_o = three_q;
  assign waits_o = waits_q;
  assign bus16_o = |width_q;
endmodule

// File: rtl/ebs_area_timing.sv
module ebs_area_timing #(
  parameter int N_AREA = 8,
  parameter int WAIT_W = 2,
  parameter int AREA_W = 3
) (
  input  logic [AREA_W-1:0]        area,
  input  logic                     addr_odd,
  input  logic                     wide,
  input  logic                     burst,
  input  logic [N_AREA-1:0]        width_cfg,
  input  logic [N_AREA-1:0]        three_cfg,
  input  logic [N_AREA*WAIT_W-1:0] waits_cfg,
  input  logic [N_AREA-1:0]        dram_cfg,
  input  logic [N_AREA-1:0]        brom_cfg,
  output ebs_pkg::kind_e           kind,
  output logic [WAIT_W-1:0]        nwait,
  output logic                     split,
  output logic [1:0]               lane
);
  import ebs_pkg::*;

  logic [WAIT_W-1:0] wfield [N_AREA];
  for (genvar g = 0; g < N_AREA; g++) begin : g_wf
    assign wfield[g] = waits_cfg[g*WAIT_W +: WAIT_W];
  end

  logic a16, a3st, adram, abrom;
  assign a16   = width_cfg[area];
  assign a3st  = three_cfg[area];
  assign adram = dram_cfg[area];
  assign abrom = brom_cfg[area];

  always_comb begin
    kind  = K_TWO;
    nwait = '0;
    if (adram) begin
      kind  = K_DRAM;
      nwait = a3st ? wfield[area] : '0;
    end else if (abrom && burst) begin
      kind  = K_TWO;
    end else if (a3st) begin
      kind  = K_THREE;
      nwait = wfield[area];
    end
  end

  always_comb begin
    split = wide && !a16;
    if (!a16)       lane = 2'b10;
    else if (wide)  lane = 2'b11;
    else            lane = addr_odd ? 2'b01 : 2'b10;
  end
endmodule

// File: rtl/ebs_cycle_fsm.sv
module ebs_cycle_fsm #(
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  ebs_pkg::kind_e    kind,
  input  logic [WAIT_W-1:0] nwait,
  input  logic              split,
  input  logic              wide,
  input  logic              write,
  input  logic [1:0]        lane,
  input  logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic              t1,
  output logic              t2,
  output logic              tw,
  output logic              t3,
  output logic              t4,
  output logic              done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [1:0]        lane_o
);
  import ebs_pkg::*;

  phase_e            ph;
  kind_e             kind_q;
  logic [WAIT_W-1:0] nwait_q, cnt;
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        lane_q;
  logic              write_q;
  logic              last;

  always_comb begin
    unique case (ph)
      PH_T2:   last = (kind_q == K_TWO);
      PH_T3:   last = (kind_q == K_THREE);
      PH_T4:   last = 1'b1;
      default: last = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      kind_q  <= K_TWO;
      nwait_q <= '0;
      cnt     <= '0;
      pend_q  <= 1'b0;
      addr_q  <= '0;
      lane_q  <= '0;
      write_q <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE: if (start) begin
          ph      <= PH_T1;
          kind_q  <= kind;
          nwait_q <= nwait;
          cnt     <= nwait;
          pend_q  <= split;
          lane_q  <= lane;
          write_q <= write;
          addr_q  <= (wide) ? {addr[ADDR_W-1:1], 1'b0} : addr;
        end
        PH_T1: ph <= PH_T2;
        PH_T2: begin
          if (kind_q == K_THREE)     ph <= (cnt != '0) ? PH_TW : PH_T3;
          else if (kind_q == K_DRAM) ph <= PH_T3;
        end
        PH_TW: begin
          cnt <= cnt - 1'b1;
          if (cnt == WAIT_W'(1)) ph <= (kind_q == K_DRAM) ? PH_T4 : PH_T3;
        end
        PH_T3: if (kind_q == K_DRAM) ph <= (cnt != '0) ? PH_TW : PH_T4;
        default: ;
      endcase
      if (last) begin
        if (pend_q) begin
          ph        <= PH_T1;
          pend_q    <= 1'b0;
          cnt       <= nwait_q;
          addr_q[0] <= 1'b1;
        end else begin
          ph <= PH_IDLE;
        end
      end
    end
  end

  assign ready     = (ph == PH_IDLE);
  assign t1        = (ph == PH_T1);
  assign t2        = (ph == PH_T2);
  assign tw        = (ph == PH_TW);
  assign t3        = (ph == PH_T3);
  assign t4        = (ph == PH_T4);
  assign done      = last && !pend_q;
  assign bus_addr  = addr_q;
  assign bus_write = write_q;
  assign lane_o    = lane_q;
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int ADDR_W = 24,
  parameter int N_AREA = 8,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic [7:0]        dram_area,
  input  logic [7:0]        brom_area,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wide,
  input  logic              req_write,
  input  logic              req_burst,
  output logic              ready,
  output logic              st_t1,
  output logic              st_t2,
  output logic              st_tw,
  output logic              st_t3,
  output logic              st_t4,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [1:0]        byte_lane,
  output logic              bus16_mode,
  output logic              done
);
  import ebs_pkg::*;
  localparam int AREA_W = $clog2(N_AREA);

  logic [N_AREA-1:0]        width_c, three_c;
  logic [N_AREA*WAIT_W-1:0] waits_c;
  kind_e                    kind;
  logic [WAIT_W-1:0]        nwait;
  logic                     split;
  logic [1:0]               lane;

  ebs_cfg_regs #(.N_AREA(N_AREA), .WAIT_W(WAIT_W), .REG_W(8)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .width_o(width_c), .three_o(three_c), .waits_o(waits_c), .bus16_o(bus16_mode)
  );

  ebs_area_timing #(.N_AREA(N_AREA), .WAIT_W(WAIT_W), .AREA_W(AREA_W)) u_tim (
    .area(req_addr[ADDR_W-1 -: AREA_W]), .addr_odd(req_addr[0]),
    .wide(req_wide), .burst(req_burst),
    .width_cfg(width_c), .three_cfg(three_c), .waits_cfg(waits_c),
    .dram_cfg(dram_area[N_AREA-1:0]), .brom_cfg(brom_area[N_AREA-1:0]),
    .kind(kind), .nwait(nwait), .split(split), .lane(lane)
  );

  ebs_cycle_fsm #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_fsm (
    .clk(clk), .rst(rst), .start(req_valid), .kind(kind), .nwait(nwait),
    .split(split), .wide(req_wide), .write(req_write), .lane(lane), .addr(req_addr),
    .ready(ready), .t1(st_t1), .t2(st_t2), .tw(st_tw), .t3(st_t3), .t4(st_t4),
    .done(done), .bus_addr(bus_addr), .bus_write(bus_write), .lane_o(byte_lane)
  );
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk (
  input logic clk,
  input logic rst,
  input logic ready,
  input logic st_t1,
  input logic st_t2,
  input logic st_tw,
  input logic st_t3,
  input logic st_t4,
  input logic done
);
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_t1, st_t2, st_tw, st_t3, st_t4}));
  a_r9_ready_no_strobe: assert property (@(posedge clk) disable iff (rst)
    ready |-> !(st_t1 || st_t2 || st_tw || st_t3 || st_t4));
  a_r4_t1_then_t2: assert property (@(posedge clk) disable iff (rst)
    st_t1 |=> st_t2);
  a_r4_tw_after_t2_tw_t3: assert property (@(posedge clk) disable iff (rst)
    $rose(st_tw) |-> $past(st_t2 || st_t3));
  a_r5_t4_after_t3_or_tw: assert property (@(posedge clk) disable iff (rst)
    st_t4 |-> $past(st_t3 || st_tw));
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_in_final: assert property (@(posedge clk) disable iff (rst)
    done |-> (st_t2 || st_t3 || st_t4));
endmodule

bind ext_bus_seq ext_bus_seq_chk u_chk (
  .clk(clk), .rst(rst), .ready(ready), .st_t1(st_t1), .st_t2(st_t2),
  .st_tw(st_tw), .st_t3(st_t3), .st_t4(st_t4), .done(done)
);

// File: tb/ext_bus_seq_tb_top.sv
module ext_bus_seq_tb_top;
  localparam int ADDR_W = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] dram_area = 8'b0110_0000;
  logic [7:0] brom_area = 8'b1000_0000;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_wide = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic ready, st_t1, st_t2, st_tw, st_t3, st_t4, bus_write, bus16_mode, done;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0] byte_lane;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ext_bus_seq #(.ADDR_W(ADDR_W)) dut_i (.*);

  // fields: area[18:16] wide[15] burst[14] odd[13] tot[12:8] tw[7:4] halves[3:2] lane[1:0]
  localparam int NV = 13;
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b0, 1'b1, 5'd3,  4'd0, 2'd1, 2'b01}, // R4 n=0, R7 odd byte
    {3'd1, 1'b1, 1'b0, 1'b0, 5'd2,  4'd0, 2'd1, 2'b11}, // R3 wait field 3 ignored, R7 word
    {3'd2, 1'b0, 1'b0, 1'b0, 5'd5,  4'd2, 2'd1, 2'b10}, // R4 n=2
    {3'd3, 1'b1, 1'b0, 1'b0, 5'd6,  4'd3, 2'd1, 2'b11}, // R4 n=3
    {3'd4, 1'b0, 1'b0, 1'b1, 5'd4,  4'd1, 2'd1, 2'b10}, // R7 8-bit area odd byte
    {3'd4, 1'b1, 1'b0, 1'b0, 5'd8,  4'd2, 2'd2, 2'b10}, // R8 split
    {3'd5, 1'b0, 1'b0, 1'b0, 5'd4,  4'd0, 2'd1, 2'b10}, // R5 state bit 0
    {3'd6, 1'b0, 1'b0, 1'b0, 5'd6,  4'd2, 2'd1, 2'b10}, // R5 state bit 1
    {3'd6, 1'b1, 1'b0, 1'b0, 5'd12, 4'd4, 2'd2, 2'b10}, // R5 R8 DRAM split
    {3'd7, 1'b0, 1'b0, 1'b0, 5'd4,  4'd1, 2'd1, 2'b10}, // R6 first beat
    {3'd7, 1'b0, 1'b1, 1'b0, 5'd2,  4'd0, 2'd1, 2'b10}, // R6 burst beat
    {3'd7, 1'b1, 1'b1, 1'b0, 5'd4,  4'd0, 2'd2, 2'b10}, // R6 R8 burst split
    {3'd2, 1'b0, 1'b1, 1'b0, 5'd5,  4'd2, 2'd1, 2'b10}  // R6 burst ignored outside ROM
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Issues one request and measures the resulting access at negedges.
  task automatic run_req(input logic [2:0] area, input logic wide, input logic burst,
                         input logic odd, input logic also_cfg,
                         output int tot, output int tw, output int halves,
                         output int lane1, output int addr2, output int dones,
                         output int gaps);
    int started = 0;
    @(negedge clk);
    req_valid = 1'b1; req_wide = wide; req_burst = burst; req_write = 1'b1;
    req_addr = {area, 20'h00010, 1'b0} | {{(ADDR_W-1){1'b0}}, odd};
    if (also_cfg) begin
      cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 8'b1100_1100; // area 2 waits -> 0
    end
    tot = 0; tw = 0; halves = 0; lane1 = -1; addr2 = -1; dones = 0; gaps = 0;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    for (int c = 0; c < 64; c++) begin
      if (st_t1 || st_t2 || st_tw || st_t3 || st_t4) begin
        started = 1;
        tot++;
        if (st_tw) tw++;
        if (st_t1) begin
          halves++;
          if (halves == 1) lane1 = byte_lane;
          if (halves == 2) addr2 = bus_addr[0];
        end
      end else if (started != 0) begin
        gaps++;
      end
      if (done) begin
        dones++;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int tot, tw, hv, ln, a2, dn, gp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset strobes", {st_t1, st_t2, st_tw, st_t3, st_t4, done}, 0);
    check("R1 reset ready", ready, 1);
    check("R2 reset bus16", bus16_mode, 1);
    // R1 reset config: area 5 is DRAM, so use area 3 (16-bit, 3-state, 3 waits)
    run_req(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, tot, tw, hv, ln, a2, dn, gp);
    check("R1 reset total states", tot, 6);
    check("R1 reset waits", tw, 3);
    check("R1 reset lane", ln, 2'b10);
    // R2 all 8-bit
    cfg_write(2'd0, 8'h00);
    @(negedge clk);
    check("R2 all 8-bit mode", bus16_mode, 0);
    cfg_write(2'd0, 8'h80);
    @(negedge clk);
    check("R2 one 16-bit area", bus16_mode, 1);
    // R10 program table configuration
    cfg_write(2'd0, 8'h0F);
    cfg_write(2'd1, 8'hDD);
    cfg_write(2'd2, 8'h6D);
    cfg_write(2'd3, 8'hEC);
    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      e = VEC[v];
      run_req(e[18:16], e[15], e[14], e[13], 1'b0, tot, tw, hv, ln, a2, dn, gp);
      check($sformatf("R3-6 vec%0d states", v), tot, int'(e[12:8]));
      check($sformatf("R4 vec%0d waits", v), tw, int'(e[7:4]));
      check($sformatf("R8 vec%0d halves", v), hv, int'(e[3:2]));
      check($sformatf("R7 vec%0d lane", v), ln, int'(e[1:0]));
      check($sformatf("R9 vec%0d one done", v), dn, 1);
      check($sformatf("R8 vec%0d no gap", v), gp, 0);
      if (e[3:2] == 2'd2) check($sformatf("R8 vec%0d second addr odd", v), a2, 1);
    end
    // R10 config write on the acceptance edge: area 2 keeps 2 waits
    run_req(3'd2, 1'b0, 1'b0, 1'b0, 1'b1, tot, tw, hv, ln, a2, dn, gp);
    check("R10 same-edge write old waits", tw, 2);
    run_req(3'd2, 1'b0, 1'b0, 1'b0, 1'b0, tot, tw, hv, ln, a2, dn, gp);
    check("R10 next request new waits", tw, 0);
    check("R4 n=0 states", tot, 3);
    // R9 ready back after access
    check("R9 ready after done", ready, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule